// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the oversampling strobe that paces a serial transmitter and receiver. The strobe comes from the system clock and a fixed-point divisor. The divisor has a 16-bit whole part and a 6-bit fraction, so its resolution is 1/64 of a clock. Each part is written through its own load port into a staging register. The staged value is ignored until a separate line-control write strobe arrives. At that strobe both parts move together into the active divisor.

The sample tick runs at clock / (whole + fraction/64), which is sixteen times the baud rate. A whole divisor cannot hit that average exactly, so a 6-bit accumulator gathers the fraction once per tick period. On each carry out of the accumulator, the following period is stretched by one clock. A second strobe, the bit tick, fires on every sixteenth sample tick and marks the baud rate itself. A parameter can remove it.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, the staged and active divisors are zero and neither `sample_tick` nor `bit_tick` is ever asserted until a non-zero whole part is committed.
- R2: A write on `whole_wr_en` or `frac_wr_en` changes only the staged value. Tick spacing keeps following the old active divisor until `lcr_wr_en` is seen.
- R3: On a clock edge where `lcr_wr_en` is high, the staged divisor becomes active and the period counter, accumulator and stretch flag clear. The first `sample_tick` is high exactly WHOLE clock edges after that commit edge.
- R4: Number the sample ticks after a commit k = 1, 2, …. For k ≥ 2, the clocks between tick k-1 and tick k equal WHOLE + floor((k-1)·FRAC/64) − floor((k-2)·FRAC/64). Every period is therefore WHOLE or WHOLE+1 clocks.
- R5: The first 65 sample ticks after a commit span exactly 65·WHOLE + FRAC clocks from the commit edge.
- R6: With FRAC = 0, every period is exactly WHOLE clocks.
- R7: A committed whole part of zero disables the generator. No tick of either kind appears, whatever the fraction.
- R8: `bit_tick` is high together with the 16th, 32nd, 48th, … sample tick counted from the last commit. It is never high without `sample_tick`.
- R9: When a staging write and `lcr_wr_en` occur on the same edge, the commit takes the value staged before that edge. The new write stays staged for the next commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| whole_wr_en | input | 1 | Load strobe for the staged whole part |
| whole_wr_data | input | 16 | Whole part of the divisor |
| frac_wr_en | input | 1 | Load strobe for the staged fraction |
| frac_wr_data | input | 6 | Fraction of the divisor in 1/64 steps |
| lcr_wr_en | input | 1 | Line-control write strobe; commits the staged divisor |
| sample_tick | output | 1 | Oversampling strobe at 16x baud |
| bit_tick | output | 1 | Strobe at 1x baud, every 16th sample tick |

## Verification
The bound checker checks four rules on every cycle:
- the active divisor holds steady between commits;
- a commit loads exactly the value staged before its edge;
- a zero whole part produces no ticks;
- each gap between ticks within one commit epoch is WHOLE or WHOLE+1 clocks, and a bit tick never appears without a sample tick.

Only the bench scenarios can show two further behaviours. One is the exact placement of the stretched periods and the 65-period total that proves the fraction is honoured on average. The other is the latency from the commit to the first tick, including the same-edge write-and-commit ordering.

// File: rtl/btg_pkg.sv
package btg_pkg;
  localparam int DEF_WHOLE_W    = 16;
  localparam int DEF_FRAC_W     = 6;
  localparam int DEF_OVERSAMPLE = 16;
endpackage

// File: rtl/btg_div_stage.sv
module btg_div_stage #(
  parameter int WHOLE_W = btg_pkg::DEF_WHOLE_W,
  parameter int FRAC_W  = btg_pkg::DEF_FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               whole_we,
  input  logic [WHOLE_W-1:0] whole_wd,
  input  logic               frac_we,
  input  logic [FRAC_W-1:0]  frac_wd,
  input  logic               commit,
  output logic [WHOLE_W-1:0] stg_whole,
  output logic [FRAC_W-1:0]  stg_frac,
  output logic [WHOLE_W-1:0] act_whole,
  output logic [FRAC_W-1:0]  act_frac
);
  logic [WHOLE_W-1:0] stg_whole_d, act_whole_d;
  logic [FRAC_W-1:0]  stg_frac_d, act_frac_d;

  // Next state: the commit copies the staging registers as they stood before this edge.
  always_comb begin
    stg_whole_d = whole_we ? whole_wd : stg_whole;
    stg_frac_d  = frac_we  ? frac_wd  : stg_frac;
    act_whole_d = commit   ? stg_whole : act_whole;
    act_frac_d  = commit   ? stg_frac  : act_frac;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_whole <= '0;
      stg_frac  <= '0;
      act_whole <= '0;
      act_frac  <= '0;
    end else begin
      stg_whole <= stg_whole_d;
      stg_frac  <= stg_frac_d;
      act_whole <= act_whole_d;
      act_frac  <= act_frac_d;
    end
  end
endmodule

// File: rtl/btg_frac_counter.sv
module btg_frac_counter #(
  parameter int WHOLE_W = btg_pkg::DEF_WHOLE_W,
  parameter int FRAC_W  = btg_pkg::DEF_FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [WHOLE_W-1:0] act_whole,
  input  logic [FRAC_W-1:0]  act_frac,
  output logic               wrap,
  output logic               tick
);
  localparam int CW = WHOLE_W + 1;

  logic [CW-1:0]     cnt_q, cnt_d, last_cnt;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   acc_sum;
  logic              str_q, str_d, tick_d, running;

  always_comb begin
    running  = |act_whole;
    last_cnt = {1'b0, act_whole} + CW'(str_q) - CW'(1);
    acc_sum  = {1'b0, acc_q} + {1'b0, act_frac};
    wrap     = running && !commit && (cnt_q == last_cnt);

    cnt_d  = cnt_q + CW'(1);
    acc_d  = acc_q;
    str_d  = str_q;
    tick_d = 1'b0;
    if (commit) begin
      cnt_d = '0;
      acc_d = '0;
      str_d = 1'b0;
    end else if (!running) begin
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d          = '0;
      {str_d, acc_d} = acc_sum;
      tick_d         = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      str_q <= 1'b0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      str_q <= str_d;
      tick  <= tick_d;
    end
  end
endmodule

// File: rtl/btg_bit_div.sv
module btg_bit_div #(
  parameter int OVERSAMPLE = btg_pkg::DEF_OVERSAMPLE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic wrap,
  output logic bit_tick
);
  localparam int SW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [SW-1:0] LAST = SW'(OVERSAMPLE - 1);

  logic [SW-1:0] sub_q, sub_d;
  logic          bit_d;

  always_comb begin
    sub_d = sub_q;
    bit_d = 1'b0;
    if (commit) begin
      sub_d = '0;
    end else if (wrap) begin
      bit_d = (sub_q == LAST);
      sub_d = (sub_q == LAST) ? '0 : sub_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q    <= '0;
      bit_tick <= 1'b0;
    end else begin
      sub_q    <= sub_d;
      bit_tick <= bit_d;
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int WHOLE_W     = btg_pkg::DEF_WHOLE_W,
  parameter int FRAC_W      = btg_pkg::DEF_FRAC_W,
  parameter int OVERSAMPLE  = btg_pkg::DEF_OVERSAMPLE,
  parameter bit BIT_TICK_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               whole_wr_en,
  input  logic [WHOLE_W-1:0] whole_wr_data,
  input  logic               frac_wr_en,
  input  logic [FRAC_W-1:0]  frac_wr_data,
  input  logic               lcr_wr_en,
  output logic               sample_tick,
  output logic               bit_tick
);
  logic [WHOLE_W-1:0] stg_whole, act_whole;
  logic [FRAC_W-1:0]  stg_frac, act_frac;
  logic               wrap;

  btg_div_stage #(.WHOLE_W(WHOLE_W), .FRAC_W(FRAC_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .whole_we(whole_wr_en), .whole_wd(whole_wr_data),
    .frac_we(frac_wr_en), .frac_wd(frac_wr_data),
    .commit(lcr_wr_en),
    .stg_whole(stg_whole), .stg_frac(stg_frac),
    .act_whole(act_whole), .act_frac(act_frac)
  );

  btg_frac_counter #(.WHOLE_W(WHOLE_W), .FRAC_W(FRAC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .commit(lcr_wr_en),
    .act_whole(act_whole), .act_frac(act_frac),
    .wrap(wrap), .tick(sample_tick)
  );

  generate
    if (BIT_TICK_EN) begin : g_bit
      btg_bit_div #(.OVERSAMPLE(OVERSAMPLE)) u_bit (
        .clk(clk), .rst_n(rst_n), .commit(lcr_wr_en),
        .wrap(wrap), .bit_tick(bit_tick)
      );
    end else begin : g_nobit
      assign bit_tick = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/btg_checker.sv
module btg_checker #(
  parameter int WHOLE_W = btg_pkg::DEF_WHOLE_W,
  parameter int FRAC_W  = btg_pkg::DEF_FRAC_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lcr_wr_en,
  input logic               sample_tick,
  input logic               bit_tick,
  input logic [WHOLE_W-1:0] stg_whole,
  input logic [FRAC_W-1:0]  stg_frac,
  input logic [WHOLE_W-1:0] act_whole,
  input logic [FRAC_W-1:0]  act_frac
);
  localparam int GW = WHOLE_W + 2;
  logic [GW-1:0] gap;
  logic          seen;

  // Gap counter: clocks since the previous sample tick within the current commit epoch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= GW'(1);
      seen <= 1'b0;
    end else begin
      if (sample_tick)      gap <= GW'(1);
      else if (~&gap)       gap <= gap + GW'(1);
      if (lcr_wr_en)        seen <= 1'b0;
      else if (sample_tick) seen <= 1'b1;
    end
  end

  a_r2_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !lcr_wr_en |=> ($stable(act_whole) && $stable(act_frac)));

  a_r3_commit_loads_staged: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_wr_en |=> (act_whole == $past(stg_whole) && act_frac == $past(stg_frac)));

  a_r7_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (act_whole == '0) |-> (!sample_tick && !bit_tick));

  a_r8_bit_with_sample: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  a_r4_gap_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && seen) |->
      (gap == GW'(act_whole) || gap == GW'(act_whole) + GW'(1)));
endmodule

bind baud_tick_gen btg_checker #(.WHOLE_W(WHOLE_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lcr_wr_en(lcr_wr_en),
  .sample_tick(sample_tick), .bit_tick(bit_tick),
  .stg_whole(stg_whole), .stg_frac(stg_frac),
  .act_whole(act_whole), .act_frac(act_frac)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        whole_wr_en = 1'b0;
  logic [15:0] whole_wr_data = '0;
  logic        frac_wr_en = 1'b0;
  logic [5:0]  frac_wr_data = '0;
  logic        lcr_wr_en = 1'b0;
  logic        sample_tick, bit_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n),
    .whole_wr_en(whole_wr_en), .whole_wr_data(whole_wr_data),
    .frac_wr_en(frac_wr_en), .frac_wr_data(frac_wr_data),
    .lcr_wr_en(lcr_wr_en),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  // {whole, frac} vectors
  localparam logic [21:0] VEC [0:5] = '{
    {16'd43, 6'd26}, {16'd7, 6'd0}, {16'd3, 6'd63},
    {16'd1, 6'd1}, {16'd1, 6'd0}, {16'd260, 6'd27}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic stage(input int w, input int f);
    @(negedge clk);
    whole_wr_en = 1'b1; whole_wr_data = 16'(w);
    frac_wr_en  = 1'b1; frac_wr_data  = 6'(f);
    @(negedge clk);
    whole_wr_en = 1'b0; frac_wr_en = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk); lcr_wr_en = 1'b1;
    @(negedge clk); lcr_wr_en = 1'b0;
  endtask

  task automatic quiet(input int n, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sample_tick || bit_tick) hits++;
    end
    chk(hits == 0, req, hits, 0);
  endtask

  // Measures n sample ticks; the clock count starts at the last commit edge or tick.
  task automatic measure(input int w, input int f, input int n, input string tag);
    int cyc = 0;
    int last = 0;
    int k = 0;
    int p, e;
    while (k < n && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      if (bit_tick && !sample_tick) chk(1'b0, {tag, " R8 bit without sample"}, 1, 0);
      if (sample_tick) begin
        k++;
        p = cyc - last;
        last = cyc;
        e = (k == 1) ? w : w + ((k - 1) * f) / 64 - ((k - 2) * f) / 64;
        if (k == 1)      chk(p == e, {tag, " R3 first period"}, p, e);
        else if (f == 0) chk(p == e, {tag, " R6 flat period"}, p, e);
        else             chk(p == e, {tag, " R4 period"}, p, e);
        if ((k % 16) == 0 || bit_tick)
          chk(bit_tick == ((k % 16) == 0), {tag, " R8 bit tick"}, int'(bit_tick), int'((k % 16) == 0));
      end
    end
    chk(k == n, {tag, " tick count"}, k, n);
    if (n == 65) chk(last == 65 * w + f, {tag, " R5 65-period span"}, last, 65 * w + f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!sample_tick && !bit_tick, "R1 outputs low in reset", int'(sample_tick), 0);
    rst_n = 1'b1;
    quiet(40, "R1 idle after reset");

    // Table-driven main function
    for (int i = 0; i < 6; i++) begin
      stage(int'(VEC[i][21:6]), int'(VEC[i][5:0]));
      commit();
      measure(int'(VEC[i][21:6]), int'(VEC[i][5:0]), 65, $sformatf("vec%0d", i));
    end

    // R7: zero whole part disables whatever the fraction
    stage(0, 40);
    commit();
    quiet(300, "R7 zero whole disables");

    // R2: staged but uncommitted value has no effect while disabled
    stage(5, 0);
    quiet(100, "R2 staged while disabled");
    commit();
    measure(5, 0, 3, "R2 commit");
    // R2: staging while running leaves the period alone
    stage(9, 0);
    while (!sample_tick) @(negedge clk);
    measure(5, 0, 4, "R2 running");

    // R9: same-edge write and commit takes the older staged value (9)
    @(negedge clk);
    whole_wr_en = 1'b1; whole_wr_data = 16'd12;
    frac_wr_en = 1'b1; frac_wr_data = 6'd0;
    lcr_wr_en = 1'b1;
    @(negedge clk);
    whole_wr_en = 1'b0; frac_wr_en = 1'b0; lcr_wr_en = 1'b0;
    measure(9, 0, 3, "R9 same edge");
    commit();
    measure(12, 0, 3, "R9 next commit");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule